// File: doc/BRIEF.md
# Base Address Allocation Engine

This block is a small sequential engine that hands out bus addresses to the regions of a set of devices, the way boot firmware places device windows after enumeration. A single start pulse begins a walk over a number of devices given on an input. For each device the engine looks at seven region descriptors in turn. Slots 0 to 5 are ordinary regions and slot 6 is the expansion ROM. A descriptor gives a size in bytes and a flag that marks an I/O region. The engine reads descriptors through a combinational lookup port. It then places each region in one of two address spaces, each with its own running pointer, and programs the result through a configuration write/read port.

For every region it places, the engine does three configuration transactions in order. It writes the region's base register. It reads the device's command register. It writes the command register back with the decode-enable bit for that region's address space set. When the walk is over it raises a one-cycle completion pulse. Two sticky flags report regions with an invalid size and a walk that ran out of address space.

The controller has seven named states. IDLE waits for start. FETCH evaluates the current descriptor. BAR_WR programs the base register. CMD_RD fetches the command register. CMD_WR writes the command register back. STEP moves to the next region or device. FINISH emits the completion pulse.

The transitions are as follows. IDLE goes to FETCH on start, or to FINISH on start when the device count is zero. FETCH goes to BAR_WR when the region is placed. FETCH goes to STEP for a zero or invalid size. FETCH goes to FINISH on exhaustion. BAR_WR goes to CMD_RD on ack. CMD_RD goes to CMD_WR on ack. CMD_WR goes to STEP on ack. STEP goes to FETCH while regions remain, or to FINISH after slot 6 of the last device. FINISH always goes to IDLE.

Top module: `bar_alloc_engine`

## Requirements
- R1: Every start reloads the I/O pointer with 0x0000C000 and the memory pointer with 0xF0000000, so that each walk places regions from those two origins.
- R2: A region of size S gets base = (P + S - 1) & ~(S - 1), where P is its space's pointer. That pointer then becomes base + S, so a later region of the same space never overlaps it.
- R3: A region whose size is zero produces no configuration transaction and leaves both pointers unchanged.
- R4: A nonzero size that is not a power of two sets err_size. That region is skipped with no transaction and no pointer change, and the walk continues.
- R5: When base + S would exceed 0x10000 for an I/O region, or 2^32 for a memory region, overflow is set. No transaction is issued for that region or any later one, and done follows.
- R6: The base of slot n (0 to 5) is written at offset 0x10 + 4*n. The base of slot 6 is written at offset 0x30. Slot 6 always takes the memory pointer, whatever its I/O flag says.
- R7: After each base write, the engine reads offset 0x04 and then writes offset 0x04 with the value read OR 1 for an I/O region, or OR 2 for a memory or ROM region.
- R8: Regions are visited in ascending slot order within a device, and devices in ascending number from 0 to dev_count-1. A dev_count of zero gives done with no transaction.
- R9: At most one configuration request is outstanding. cfg_req and its dev, offset, write flag and data hold steady until the cycle in which cfg_ack is sampled high.
- R10: done is high for exactly one cycle per walk. err_size and overflow are cleared by start and otherwise keep their value after done.
- R11: After reset cfg_req, done, err_size and overflow are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a walk (taken in IDLE only) |
| dev_count | input | DEV_W+1 | Number of devices to walk |
| desc_dev | output | DEV_W | Device whose descriptor is being looked up |
| desc_idx | output | 3 | Region slot being looked up (6 = ROM) |
| desc_size | input | 32 | Region size in bytes, combinational reply |
| desc_io | input | 1 | Region lives in I/O space, combinational reply |
| cfg_req | output | 1 | Configuration request valid |
| cfg_we | output | 1 | 1 = write, 0 = read |
| cfg_dev | output | DEV_W | Target device |
| cfg_off | output | 8 | Register byte offset |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | Request accepted; read data valid in the same cycle |
| cfg_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-walk pulse |
| err_size | output | 1 | Sticky: an invalid region size was seen |
| overflow | output | 1 | Sticky: an address space ran out |

## Verification
The engine is driven with four device tables, and each one separates a different kind of fault.

The first table mixes I/O, memory, zero-sized and ROM regions across two devices, with sizes chosen so that some bases must be rounded up. A design that shares one pointer, skips the rounding, uses the wrong offset for the ROM slot or sets the wrong enable bit produces a different write stream.

The second table puts an invalid size in front of valid ones. This shows whether the invalid region is skipped without stopping the walk. The third table fills the I/O space exactly to its top and then asks for more. This checks the exact boundary and that nothing is issued once space runs out. The fourth table has zero devices.

The acknowledge latency is varied so that request holding is exercised.

// File: rtl/bar_alloc_pkg.sv
package bar_alloc_pkg;

    localparam int NUM_SLOTS  = 7;
    localparam int SLOT_W     = 3;
    localparam logic [SLOT_W-1:0] ROM_SLOT = 3'd6;
    localparam logic [7:0] BAR0_OFFSET = 8'h10;
    localparam logic [7:0] ROM_OFFSET  = 8'h30;
    localparam logic [7:0] CMD_OFFSET  = 8'h04;
    localparam logic [31:0] CMD_IO_EN  = 32'h0000_0001;
    localparam logic [31:0] CMD_MEM_EN = 32'h0000_0002;

    typedef enum logic [2:0] {
        IDLE,
        FETCH,
        BAR_WR,
        CMD_RD,
        CMD_WR,
        STEP,
        FINISH
    } alloc_state_t;

    function automatic logic [7:0] slot_offset(input logic [SLOT_W-1:0] slot);
        if (slot == ROM_SLOT)
            return ROM_OFFSET;
        return BAR0_OFFSET + {3'b000, slot, 2'b00};
    endfunction

endpackage

// File: rtl/bar_align_calc.sv
module bar_align_calc #(
    parameter int IO_AW  = 16,
    parameter int MEM_AW = 32
) (
    input  logic [32:0] ptr,
    input  logic [31:0] size,
    input  logic        io_space,
    output logic [31:0] base,
    output logic [32:0] next_ptr,
    output logic        is_zero,
    output logic        is_pow2,
    output logic        exhausted
);
    localparam logic [33:0] IO_LIMIT  = 34'd1 << IO_AW;
    localparam logic [33:0] MEM_LIMIT = 34'd1 << MEM_AW;

    logic [33:0] sz_w;
    logic [33:0] mask;
    logic [33:0] rounded;
    logic [33:0] end_addr;
    logic [33:0] limit;

    always_comb begin
        sz_w      = {2'b00, size};
        mask      = sz_w - 34'd1;
        rounded   = ({1'b0, ptr} + mask) & ~mask;
        end_addr  = rounded + sz_w;
        limit     = io_space ? IO_LIMIT : MEM_LIMIT;
        is_zero   = (size == 32'd0);
        is_pow2   = ((size & (size - 32'd1)) == 32'd0);
        exhausted = (end_addr > limit);
        base      = rounded[31:0];
        next_ptr  = end_addr[32:0];
    end
endmodule

// File: rtl/bar_ptr_bank.sv
module bar_ptr_bank #(
    parameter logic [31:0] IO_START  = 32'h0000_C000,
    parameter logic [31:0] MEM_START = 32'hF000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reload,
    input  logic        commit,
    input  logic        io_space,
    input  logic [32:0] new_ptr,
    output logic [32:0] cur_ptr
);
    logic [32:0] io_ptr;
    logic [32:0] mem_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            io_ptr  <= {1'b0, IO_START};
            mem_ptr <= {1'b0, MEM_START};
        end else if (commit) begin
            if (io_space)
                io_ptr <= new_ptr;
            else
                mem_ptr <= new_ptr;
        end
    end

    assign cur_ptr = io_space ? io_ptr : mem_ptr;
endmodule

// File: rtl/bar_alloc_engine.sv
module bar_alloc_engine
    import bar_alloc_pkg::*;
#(
    parameter int          DEV_W     = 4,
    parameter int          IO_AW     = 16,
    parameter int          MEM_AW    = 32,
    parameter logic [31:0] IO_START  = 32'h0000_C000,
    parameter logic [31:0] MEM_START = 32'hF000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DEV_W:0]      dev_count,
    output logic [DEV_W-1:0]    desc_dev,
    output logic [SLOT_W-1:0]   desc_idx,
    input  logic [31:0]         desc_size,
    input  logic                desc_io,
    output logic                cfg_req,
    output logic                cfg_we,
    output logic [DEV_W-1:0]    cfg_dev,
    output logic [7:0]          cfg_off,
    output logic [31:0]         cfg_wdata,
    input  logic                cfg_ack,
    input  logic [31:0]         cfg_rdata,
    output logic                done,
    output logic                err_size,
    output logic                overflow
);
    alloc_state_t state, state_nx;

    logic [DEV_W-1:0]  dev_q;
    logic [SLOT_W-1:0] slot_q;
    logic [DEV_W:0]    count_q;
    logic [31:0]       base_q;
    logic              kind_io_q;
    logic [31:0]       cmd_q;

    logic              use_io;
    logic [32:0]       cur_ptr;
    logic [32:0]       next_ptr;
    logic [31:0]       base_c;
    logic              sz_zero, sz_pow2, sz_exh;
    logic              place;
    logic              last_slot, last_dev;

    assign use_io    = desc_io && (slot_q != ROM_SLOT);
    assign last_slot = (slot_q == ROM_SLOT);
    assign last_dev  = (({1'b0, dev_q} + 1'b1) == count_q);
    assign place     = (state == FETCH) && !sz_zero && sz_pow2 && !sz_exh;

    bar_align_calc #(
        .IO_AW (IO_AW),
        .MEM_AW(MEM_AW)
    ) u_align (
        .ptr      (cur_ptr),
        .size     (desc_size),
        .io_space (use_io),
        .base     (base_c),
        .next_ptr (next_ptr),
        .is_zero  (sz_zero),
        .is_pow2  (sz_pow2),
        .exhausted(sz_exh)
    );

    bar_ptr_bank #(
        .IO_START (IO_START),
        .MEM_START(MEM_START)
    ) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  ((state == IDLE) && start),
        .commit  (place),
        .io_space(use_io),
        .new_ptr (next_ptr),
        .cur_ptr (cur_ptr)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE: begin
                if (start)
                    state_nx = (dev_count == '0) ? FINISH : FETCH;
            end
            FETCH: begin
                if (sz_zero || !sz_pow2)
                    state_nx = STEP;
                else if (sz_exh)
                    state_nx = FINISH;
                else
                    state_nx = BAR_WR;
            end
            BAR_WR:  if (cfg_ack) state_nx = CMD_RD;
            CMD_RD:  if (cfg_ack) state_nx = CMD_WR;
            CMD_WR:  if (cfg_ack) state_nx = STEP;
            STEP: begin
                if (last_slot && last_dev)
                    state_nx = FINISH;
                else
                    state_nx = FETCH;
            end
            FINISH:  state_nx = IDLE;
            default: state_nx = IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= IDLE;
            dev_q     <= '0;
            slot_q    <= '0;
            count_q   <= '0;
            base_q    <= '0;
            kind_io_q <= 1'b0;
            cmd_q     <= '0;
            err_size  <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                IDLE: begin
                    if (start) begin
                        dev_q    <= '0;
                        slot_q   <= '0;
                        count_q  <= dev_count;
                        err_size <= 1'b0;
                        overflow <= 1'b0;
                    end
                end
                FETCH: begin
                    if (!sz_zero && !sz_pow2)
                        err_size <= 1'b1;
                    else if (!sz_zero && sz_exh)
                        overflow <= 1'b1;
                    if (place) begin
                        base_q    <= base_c;
                        kind_io_q <= use_io;
                    end
                end
                CMD_RD: begin
                    if (cfg_ack)
                        cmd_q <= cfg_rdata | (kind_io_q ? CMD_IO_EN : CMD_MEM_EN);
                end
                STEP: begin
                    if (last_slot) begin
                        slot_q <= '0;
                        if (!last_dev)
                            dev_q <= dev_q + 1'b1;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // output logic
    always_comb begin
        desc_dev  = dev_q;
        desc_idx  = slot_q;
        cfg_dev   = dev_q;
        cfg_req   = 1'b0;
        cfg_we    = 1'b0;
        cfg_off   = 8'h00;
        cfg_wdata = 32'h0;
        done      = 1'b0;
        unique case (state)
            BAR_WR: begin
                cfg_req   = 1'b1;
                cfg_we    = 1'b1;
                cfg_off   = slot_offset(slot_q);
                cfg_wdata = base_q;
            end
            CMD_RD: begin
                cfg_req = 1'b1;
                cfg_off = CMD_OFFSET;
            end
            CMD_WR: begin
                cfg_req   = 1'b1;
                cfg_we    = 1'b1;
                cfg_off   = CMD_OFFSET;
                cfg_wdata = cmd_q;
            end
            FINISH:  done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bar_alloc_chk.sv
module bar_alloc_chk #(
    parameter int DEV_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [31:0]      desc_size,
    input logic             cfg_req,
    input logic             cfg_we,
    input logic [DEV_W-1:0] cfg_dev,
    input logic [7:0]       cfg_off,
    input logic [31:0]      cfg_wdata,
    input logic             cfg_ack,
    input logic             done,
    input logic             err_size,
    input logic             overflow
);
    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a pending request holds all its fields until accepted
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_we) && $stable(cfg_off)
                                   && $stable(cfg_wdata) && $stable(cfg_dev)));

    // R2: every base written is a multiple of its region size
    a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_we && cfg_off != 8'h04) |-> ((cfg_wdata & (desc_size - 32'd1)) == 32'd0));

    // R6: writes only target the command register or a legal base register slot
    a_r6_legal_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_we) |-> (cfg_off == 8'h04 || cfg_off == 8'h30 ||
                                 (cfg_off >= 8'h10 && cfg_off <= 8'h24 && cfg_off[1:0] == 2'b00)));

    // R8: no traffic while the completion pulse is up
    a_r8_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cfg_req);

    // R10: sticky flags keep their value unless a walk is started
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_size && !start) |=> err_size);
endmodule

bind bar_alloc_engine bar_alloc_chk #(.DEV_W(DEV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .desc_size(desc_size),
    .cfg_req  (cfg_req),
    .cfg_we   (cfg_we),
    .cfg_dev  (cfg_dev),
    .cfg_off  (cfg_off),
    .cfg_wdata(cfg_wdata),
    .cfg_ack  (cfg_ack),
    .done     (done),
    .err_size (err_size),
    .overflow (overflow)
);

// File: tb/sim_bar_alloc_engine.sv
module sim_bar_alloc_engine;
    localparam int DEV_W = 4;
    localparam int NDEV  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [DEV_W:0]   dev_count = '0;
    logic [DEV_W-1:0] desc_dev;
    logic [2:0]       desc_idx;
    logic [31:0]      desc_size;
    logic             desc_io;
    logic             cfg_req, cfg_we;
    logic [DEV_W-1:0] cfg_dev;
    logic [7:0]       cfg_off;
    logic [31:0]      cfg_wdata;
    logic             cfg_ack = 1'b0;
    logic [31:0]      cfg_rdata = '0;
    logic             done, err_size, overflow;

    always #4 clk = ~clk;

    bar_alloc_engine #(.DEV_W(DEV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_count(dev_count),
        .desc_dev(desc_dev), .desc_idx(desc_idx), .desc_size(desc_size), .desc_io(desc_io),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_off(cfg_off),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .done(done), .err_size(err_size), .overflow(overflow)
    );

    // descriptor table
    logic [31:0] tbl_size [NDEV][7];
    logic        tbl_io   [NDEV][7];
    logic [31:0] dev_cmd  [NDEV];
    logic [31:0] exp_cmd  [NDEV];

    always_comb begin
        desc_size = tbl_size[desc_dev[1:0]][desc_idx < 3'd7 ? desc_idx : 3'd0];
        desc_io   = tbl_io[desc_dev[1:0]][desc_idx < 3'd7 ? desc_idx : 3'd0];
    end

    int tests = 0;
    int fails = 0;
    logic [47:0] expq[$];
    int txn_num = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // responder and monitor: acknowledges requests, compares writes against the queue
    initial begin
        int waitc;
        waitc = 0;
        forever begin
            @(negedge clk);
            if (cfg_ack) begin
                cfg_ack <= 1'b0;
            end else if (cfg_req) begin
                if (waitc >= (txn_num % 3)) begin
                    waitc = 0;
                    txn_num++;
                    cfg_ack <= 1'b1;
                    if (!cfg_we) begin
                        check(cfg_off == 8'h04, "R7 read offset", {56'h0, cfg_off}, 64'h04);
                        cfg_rdata <= dev_cmd[cfg_dev[1:0]];
                    end else begin
                        logic [47:0] got, want;
                        got = {4'h0, cfg_dev, cfg_off, cfg_wdata};
                        if (cfg_off == 8'h04)
                            dev_cmd[cfg_dev[1:0]] = cfg_wdata;
                        if (expq.size() == 0) begin
                            check(1'b0, "R8 unexpected write", {16'h0, got}, 64'h0);
                        end else begin
                            want = expq.pop_front();
                            check(got == want, "R2/R6/R7 write stream", {16'h0, got}, {16'h0, want});
                        end
                    end
                end else begin
                    waitc++;
                end
            end
        end
    end

    // driver: computes expected writes from the requirements and pushes them
    task automatic build_expected(input int ndev, output bit e_err, output bit e_ovf);
        logic [63:0] iop, memp, p, b, e, lim, sz;
        bit io, stop;
        iop = 64'hC000; memp = 64'hF000_0000; e_err = 0; e_ovf = 0; stop = 0;
        for (int d = 0; d < ndev && !stop; d++) begin
            for (int r = 0; r < 7 && !stop; r++) begin
                sz = {32'h0, tbl_size[d][r]};
                if (sz == 0) continue;                         // R3
                if ((sz & (sz - 1)) != 0) begin e_err = 1; continue; end // R4
                io  = tbl_io[d][r] && (r != 6);                // R6
                p   = io ? iop : memp;
                b   = (p + sz - 1) & ~(sz - 1);                // R2
                e   = b + sz;
                lim = io ? 64'h1_0000 : 64'h1_0000_0000;
                if (e > lim) begin e_ovf = 1; stop = 1; continue; end // R5
                if (io) iop = e; else memp = e;
                expq.push_back({4'h0, 4'(d), (r == 6) ? 8'h30 : 8'(8'h10 + 4*r), b[31:0]});
                exp_cmd[d] = exp_cmd[d] | (io ? 32'h1 : 32'h2); // R7
                expq.push_back({4'h0, 4'(d), 8'h04, exp_cmd[d]});
            end
        end
    endtask

    task automatic clear_table();
        for (int d = 0; d < NDEV; d++) begin
            dev_cmd[d] = 32'h0280_0000 | (32'(d) << 8);
            exp_cmd[d] = dev_cmd[d];
            for (int r = 0; r < 7; r++) begin
                tbl_size[d][r] = 32'h0;
                tbl_io[d][r]   = 1'b0;
            end
        end
    endtask

    task automatic run_walk(input int ndev, input string tag);
        bit e_err, e_ovf;
        int cyc;
        build_expected(ndev, e_err, e_ovf);
        @(negedge clk);
        dev_count = (DEV_W+1)'(ndev);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1, {tag, " R8 done reached"}, {63'h0, done}, 64'h1);
        @(negedge clk);
        check(done == 1'b0, {tag, " R10 done one cycle"}, {63'h0, done}, 64'h0);
        check(err_size == e_err, {tag, " R4 err_size"}, {63'h0, err_size}, {63'h0, e_err});
        check(overflow == e_ovf, {tag, " R5 overflow"}, {63'h0, overflow}, {63'h0, e_ovf});
        check(expq.size() == 0, {tag, " R3/R5 all writes seen"}, 64'(expq.size()), 64'h0);
        check(cfg_req == 1'b0, {tag, " R9 idle after done"}, {63'h0, cfg_req}, 64'h0);
        expq.delete();
    endtask

    initial begin
        clear_table();
        repeat (3) @(negedge clk);
        // R11: reset state
        check(cfg_req == 1'b0, "R11 cfg_req at reset", {63'h0, cfg_req}, 64'h0);
        check(done == 1'b0, "R11 done at reset", {63'h0, done}, 64'h0);
        check(err_size == 1'b0 && overflow == 1'b0, "R11 flags at reset",
              {62'h0, err_size, overflow}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // walk 1: mixed spaces, alignment, zero slot, ROM (R1 R2 R3 R6 R7 R8)
        clear_table();
        tbl_size[0][0] = 32'h20;      tbl_io[0][0] = 1'b1;
        tbl_size[0][1] = 32'h1000;
        tbl_size[0][3] = 32'h100;     tbl_io[0][3] = 1'b1;
        tbl_size[0][6] = 32'h1_0000;  tbl_io[0][6] = 1'b1;
        tbl_size[1][0] = 32'h10_0000;
        tbl_size[1][1] = 32'h4;       tbl_io[1][1] = 1'b1;
        tbl_size[1][5] = 32'h8;
        run_walk(2, "W1 R1");

        // walk 2: invalid size then valid ones, pointers reloaded (R1 R4)
        clear_table();
        tbl_size[0][0] = 32'h300;     tbl_io[0][0] = 1'b1;
        tbl_size[0][1] = 32'h40;      tbl_io[0][1] = 1'b1;
        tbl_size[0][2] = 32'h2000;
        tbl_size[2][4] = 32'h6000;
        tbl_size[2][5] = 32'h800;
        run_walk(3, "W2");

        // walk 3: I/O space filled to its top, then exhausted (R5)
        clear_table();
        tbl_size[0][0] = 32'h4000;    tbl_io[0][0] = 1'b1;
        tbl_size[0][1] = 32'h4;       tbl_io[0][1] = 1'b1;
        tbl_size[0][2] = 32'h1000;
        tbl_size[1][0] = 32'h10;
        run_walk(2, "W3");

        // walk 4: no devices (R8)
        clear_table();
        run_walk(0, "W4");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule